// File: doc/BRIEF.md
# Elapsed-Time Counter with Alarm Compare

This block keeps a 48-bit running count that advances by one on every cycle where a 32.768 kHz clock-enable pulse arrives. The count is fixed point: the top 33 bits hold whole seconds and the bottom 15 bits hold the fraction of a second. A host reads and loads the count as three 16-bit words over a simple single-cycle register bus. Reads return data in the same cycle and need no latch. Software that needs a consistent 48-bit value reads the three words twice and retries until both passes agree.

A second 48-bit value, the compare value, uses the same three-word layout. When a tick moves the count onto the compare value, a sticky alarm flag is set. The host clears the flag by writing a one to its bit. An interrupt line is raised while the flag is set and its enable bit in a mask register is also set.

Top module: `elapsed_alarm_timer`

## Requirements
- R1: After reset, the count, compare value, alarm flag and mask all read 0, and `irq_o` is low.
- R2: The count rises by exactly 1 on each cycle with `tick_i` high and holds its value on other cycles. A carry passes across word boundaries.
- R3: Count words sit at byte offsets 0x00 (bits 15:0), 0x02 (bits 31:16) and 0x04 (bits 47:32). Bit 15 of word 0x00 is the least significant seconds bit. Reads return the current value in the same cycle.
- R4: A write to a count word loads only that word, at the next clock edge. On a tick cycle, the written word takes the written data and the other words take the incremented value.
- R5: Compare words sit at 0x08, 0x0A and 0x0C with the same bit layout as the count, and read back what was written.
- R6: On a tick cycle where the incremented 48-bit count equals the compare value, the alarm flag is set. The flag reads as bit 0 of offset 0x3E and stays set on later ticks.
- R7: A write to 0x3E with bit 0 at 1 clears the alarm flag. With bit 0 at 0 the write leaves the flag unchanged.
- R8: When a clear and a new match occur in the same cycle, the flag stays set.
- R9: Bit 0 of offset 0x3C is the interrupt enable. `irq_o` is high exactly when both the flag and the enable are set.
- R10: Unmapped offsets read 0, and writes to them change no register. Bits 15:1 of 0x3E and 0x3C read 0.
- R11: The count wraps from all ones to zero on a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one pulse per 1/32768 s |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the same cycle |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The assertions check four rules on every cycle: the count steps by one or holds when no word is written, the flag stays set until a clear, a match beats a clear in the same cycle, and the interrupt never rises without both flag and enable. The bench scenarios cover the behaviour the assertions cannot see. These are the word offsets and bit layout, the merge of a word write with a tick, the full 48-bit match, including a word that differs only in its high half, the decoding of unmapped offsets, and wrap-around.

// File: rtl/eat_pkg.sv
package eat_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned NUM_WORDS = 3;
  localparam int unsigned ADDR_W    = 6;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_CMP  = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_MASK = 6'h3C;
  localparam logic [ADDR_W-1:0] OFF_STAT = 6'h3E;
endpackage

// File: rtl/eat_word_bank.sv
module eat_word_bank #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NUM_WORDS = 3,
  parameter bit          COUNTS    = 1'b1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        inc_i,
  input  logic [NUM_WORDS-1:0]        wr_i,
  input  logic [WORD_W-1:0]           wdata_i,
  output logic [NUM_WORDS*WORD_W-1:0] val_o,
  output logic [NUM_WORDS*WORD_W-1:0] nxt_o
);
  localparam int unsigned VAL_W = NUM_WORDS * WORD_W;

  logic [VAL_W-1:0] val_q, val_d;

  always_comb begin
    val_d = (COUNTS && inc_i) ? val_q + VAL_W'(1) : val_q;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (wr_i[w]) val_d[w*WORD_W +: WORD_W] = wdata_i; // write wins in its word only
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= val_d;
  end

  assign val_o = val_q;
  assign nxt_o = val_d;

  generate
    if (COUNTS) begin : g_cnt_chk
      p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && wr_i == '0) |=> (val_q == VAL_W'($past(val_q) + VAL_W'(1))));
      p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!inc_i && wr_i == '0) |=> $stable(val_q));
    end else begin : g_reg_chk
      p_cmp_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i == '0) |=> $stable(val_q));
    end
  endgenerate
endmodule

// File: rtl/eat_alarm_stat.sv
module eat_alarm_stat (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic clr_i,
  input  logic mask_wr_i,
  input  logic mask_d_i,
  output logic flag_o,
  output logic mask_o,
  output logic irq_o
);
  logic flag_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (match_i)    flag_q <= 1'b1; // set beats clear
      else if (clr_i) flag_q <= 1'b0;
      if (mask_wr_i)  mask_q <= mask_d_i;
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign irq_o  = flag_q & mask_q;

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> flag_q);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !match_i) |=> !flag_q);
endmodule

// File: rtl/elapsed_alarm_timer.sv
module elapsed_alarm_timer
  import eat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [5:0]        addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              irq_o
);
  localparam int unsigned VAL_W = NUM_WORDS * WORD_W;

  logic                 wr;
  logic [NUM_WORDS-1:0] cnt_wr, cmp_wr, cnt_sel, cmp_sel;
  logic [VAL_W-1:0]     cnt_val, cnt_nxt, cmp_val, cmp_nxt;
  logic                 flag, mask, match, clr, mask_wr;

  assign wr = req_i & we_i;

  genvar gw;
  generate
    for (gw = 0; gw < NUM_WORDS; gw++) begin : g_dec
      assign cnt_sel[gw] = (addr_i == ADDR_W'(OFF_CNT + 2*gw));
      assign cmp_sel[gw] = (addr_i == ADDR_W'(OFF_CMP + 2*gw));
      assign cnt_wr[gw]  = wr & cnt_sel[gw];
      assign cmp_wr[gw]  = wr & cmp_sel[gw];
    end
  endgenerate

  eat_word_bank #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .COUNTS(1'b1)) u_cnt (
    .clk_i, .rst_ni, .inc_i(tick_i), .wr_i(cnt_wr), .wdata_i,
    .val_o(cnt_val), .nxt_o(cnt_nxt)
  );

  eat_word_bank #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .COUNTS(1'b0)) u_cmp (
    .clk_i, .rst_ni, .inc_i(1'b0), .wr_i(cmp_wr), .wdata_i,
    .val_o(cmp_val), .nxt_o(cmp_nxt)
  );

  assign match   = tick_i && (cnt_nxt == cmp_val);
  assign clr     = wr && (addr_i == OFF_STAT) && wdata_i[0];
  assign mask_wr = wr && (addr_i == OFF_MASK);

  eat_alarm_stat u_stat (
    .clk_i, .rst_ni, .match_i(match), .clr_i(clr),
    .mask_wr_i(mask_wr), .mask_d_i(wdata_i[0]),
    .flag_o(flag), .mask_o(mask), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (cnt_sel[w]) rdata_o = cnt_val[w*WORD_W +: WORD_W];
      if (cmp_sel[w]) rdata_o = cmp_val[w*WORD_W +: WORD_W];
    end
    if (addr_i == OFF_STAT) rdata_o = {{(WORD_W-1){1'b0}}, flag};
    if (addr_i == OFF_MASK) rdata_o = {{(WORD_W-1){1'b0}}, mask};
  end

  p_irq_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag && mask));
  p_irq_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask |-> !irq_o);
endmodule

// File: tb/elapsed_alarm_timer_tb.sv
`timescale 1ns/1ps
module elapsed_alarm_timer_tb;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_TK = 3'd2, OP_IRQ = 3'd3, OP_WT = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [5:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t mk(logic [2:0] op, logic [5:0] a, logic [15:0] d,
                              logic [15:0] e, logic [3:0] r);
    mk = '{op: op, addr: a, data: d, exp: e, req: r};
  endfunction

  localparam int N = 57;
  localparam vec_t VEC [N] = '{
    mk(OP_RD, 6'h00, 0, 0, 1), mk(OP_RD, 6'h02, 0, 0, 1), mk(OP_RD, 6'h04, 0, 0, 1),   // R1
    mk(OP_RD, 6'h0A, 0, 0, 1), mk(OP_RD, 6'h3E, 0, 0, 1), mk(OP_RD, 6'h3C, 0, 0, 1),   // R1
    mk(OP_IRQ, 6'h00, 0, 0, 1),
    mk(OP_TK, 6'h00, 5, 0, 2), mk(OP_RD, 6'h00, 0, 16'h0005, 2),                       // R2
    mk(OP_WR, 6'h00, 16'hFFFE, 0, 4), mk(OP_TK, 6'h00, 3, 0, 2),
    mk(OP_RD, 6'h00, 0, 16'h0001, 2), mk(OP_RD, 6'h02, 0, 16'h0001, 3),                // R2 carry, R3
    mk(OP_WR, 6'h04, 16'h1234, 0, 4), mk(OP_RD, 6'h04, 0, 16'h1234, 4),
    mk(OP_RD, 6'h02, 0, 16'h0001, 4),                                                  // R4
    mk(OP_WT, 6'h00, 16'h0100, 0, 4), mk(OP_RD, 6'h00, 0, 16'h0100, 4),
    mk(OP_RD, 6'h02, 0, 16'h0001, 4),
    mk(OP_WR, 6'h08, 16'h0105, 0, 5), mk(OP_WR, 6'h0A, 16'h0001, 0, 5),
    mk(OP_WR, 6'h0C, 16'h1234, 0, 5), mk(OP_RD, 6'h0C, 0, 16'h1234, 5),
    mk(OP_RD, 6'h08, 0, 16'h0105, 5),                                                  // R5
    mk(OP_TK, 6'h00, 4, 0, 6), mk(OP_RD, 6'h3E, 0, 0, 6),
    mk(OP_TK, 6'h00, 1, 0, 6), mk(OP_RD, 6'h3E, 0, 1, 6),
    mk(OP_TK, 6'h00, 2, 0, 6), mk(OP_RD, 6'h3E, 0, 1, 6),                              // R6
    mk(OP_IRQ, 6'h00, 0, 0, 9), mk(OP_WR, 6'h3C, 1, 0, 9), mk(OP_IRQ, 6'h00, 0, 1, 9), // R9
    mk(OP_WR, 6'h3E, 0, 0, 7), mk(OP_RD, 6'h3E, 0, 1, 7),
    mk(OP_WR, 6'h3E, 1, 0, 7), mk(OP_RD, 6'h3E, 0, 0, 7),                              // R7
    mk(OP_IRQ, 6'h00, 0, 0, 9),
    mk(OP_WR, 6'h3E, 16'hFFFF, 0, 10), mk(OP_RD, 6'h3E, 0, 0, 10),
    mk(OP_WR, 6'h06, 16'hFFFF, 0, 10), mk(OP_RD, 6'h06, 0, 0, 10),
    mk(OP_RD, 6'h04, 0, 16'h1234, 10), mk(OP_RD, 6'h10, 0, 0, 10),                     // R10
    mk(OP_WR, 6'h00, 16'h0104, 0, 8), mk(OP_TK, 6'h00, 1, 0, 8),
    mk(OP_WR, 6'h00, 16'h0104, 0, 8), mk(OP_WT, 6'h3E, 16'h0001, 0, 8),
    mk(OP_RD, 6'h3E, 0, 1, 8), mk(OP_IRQ, 6'h00, 0, 1, 8),                             // R8
    mk(OP_WR, 6'h00, 16'hFFFF, 0, 11), mk(OP_WR, 6'h02, 16'hFFFF, 0, 11),
    mk(OP_WR, 6'h04, 16'hFFFF, 0, 11), mk(OP_TK, 6'h00, 1, 0, 11),
    mk(OP_RD, 6'h00, 0, 0, 11), mk(OP_RD, 6'h02, 0, 0, 11), mk(OP_RD, 6'h04, 0, 0, 11)  // R11
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  elapsed_alarm_timer u_dut (.*);

  task automatic check(string what, int req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(vec_t v);
    @(negedge clk_i);
    case (v.op)
      OP_WR, OP_WT: begin
        req_i = 1'b1; we_i = 1'b1; addr_i = v.addr; wdata_i = v.data;
        tick_i = (v.op == OP_WT);
        @(negedge clk_i);
        req_i = 1'b0; we_i = 1'b0; tick_i = 1'b0;
      end
      OP_TK: begin
        tick_i = 1'b1;
        repeat (v.data) @(negedge clk_i);
        tick_i = 1'b0;
      end
      OP_RD: begin
        req_i = 1'b1; we_i = 1'b0; addr_i = v.addr;
        #2 check($sformatf("read %h", v.addr), v.req, rdata_o, v.exp);
        req_i = 1'b0;
      end
      default: begin
        #2 check("irq", v.req, {15'b0, irq_o}, v.exp);
      end
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < N; i++) run(VEC[i]);
    // R1: reset mid-run with flag and enable set
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 check("irq after reset", 1, {15'b0, irq_o}, 16'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run(mk(OP_RD, 6'h3C, 0, 0, 1));
    run(mk(OP_RD, 6'h0C, 0, 0, 1));
    run(mk(OP_RD, 6'h3E, 0, 0, 1));
    // R4: write to middle word on tick; low word still increments
    run(mk(OP_WT, 6'h02, 16'hABCD, 0, 4));
    run(mk(OP_RD, 6'h00, 0, 16'h0001, 4));
    run(mk(OP_RD, 6'h02, 0, 16'hABCD, 4));
    // R3: seconds bit is bit 15 of the low word
    run(mk(OP_WR, 6'h00, 16'h7FFF, 0, 3));
    run(mk(OP_TK, 6'h00, 1, 0, 3));
    run(mk(OP_RD, 6'h00, 0, 16'h8000, 3));
    // R6: match in low and middle words but not high word does not set
    run(mk(OP_WR, 6'h08, 16'h8002, 0, 6));
    run(mk(OP_WR, 6'h0A, 16'hABCD, 0, 6));
    run(mk(OP_WR, 6'h0C, 16'h0001, 0, 6));
    run(mk(OP_TK, 6'h00, 2, 0, 6));
    run(mk(OP_RD, 6'h3E, 0, 0, 6));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R0 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule